// File: doc/BRIEF.md
# Scaled Watchdog Timer Core

A countdown watchdog with three 8-bit registers reached through a single-cycle write strobe and a combinational read port. Software arms it by writing a nonzero count to the timeout register. The count then falls by one on every unit tick. A unit is one second, or one minute when the scale bit is set. When the count reaches zero the block latches a sticky fired flag. If enabled, it also drives an active-low reset pulse of fixed length. Writing zero to the timeout register disables the count.

The count can be restarted in three ways: by rewriting the timeout, or by keyboard or mouse interrupt events when their enable bits are set. An expiry can be forced at once by a self-clearing status bit, or by a keyboard P20 input when that path is enabled. A four-bit interrupt-source selector is stored and read back only; the value 2 denotes SMI.

The control flow is a four-state machine:
- IDLE: disabled.
- COUNT: counting.
- PULSE: reset output low.
- HOLD: fired, waiting for the flag to be cleared.

The transitions are:
- IDLE to COUNT on a nonzero timeout write.
- IDLE or COUNT to PULSE on expiry or force, when the pulse is enabled.
- IDLE or COUNT to HOLD on expiry or force, when the pulse is disabled.
- COUNT to IDLE on a zero timeout write.
- PULSE to HOLD, or to IDLE if the flag was already cleared, after the pulse length.
- HOLD to IDLE once software clears the flag.

Top module: `wdt_core`

## Requirements
- R1: After reset all three registers read 0, `fired` is 0 and `kbrst_n` is 1.
- R2: The register addresses are as follows.
  - Address 0 is configuration: bit 3 selects minutes, bit 2 enables P20, bit 1 enables the pulse, and the other bits read 0.
  - Address 1 is the timeout register and reads the live count.
  - Address 2 is status: bit 7 enables mouse reload, bit 6 enables keyboard reload, bit 5 always reads 0, bit 4 is the fired flag, and bits 3:0 are a stored selector. Writing 1 to bit 4 leaves the flag unchanged.
  - Address 3 reads 0.
- R3: In seconds mode, writing N>0 arms the counter. The fired flag sets exactly N*SEC_CYCLES clock cycles after the write edge. The timeout register reads N minus the number of elapsed units.
- R4: With configuration bit 3 set, the expiry comes N*SEC_CYCLES*UNITS_PER_MIN cycles after the write.
- R5: Writing 0 to the timeout register stops the count; the register reads 0 and no expiry follows.
- R6: Writing a nonzero timeout while counting restarts a full period from that write.
- R7: While counting, a mouse event with status bit 7 set, or a keyboard event with status bit 6 set, reloads the last written timeout and restarts the unit. An event whose enable bit is clear has no effect.
- R8: Writing status bit 5 as 1 fires the timer on that write edge; bit 5 reads back 0.
- R9: With configuration bit 2 set, a high `kbd_p20` fires the timer on the next edge; with bit 2 clear it has no effect.
- R10: With configuration bit 1 set, an expiry drives `kbrst_n` low for exactly PULSE_CYCLES cycles. With bit 1 clear, `kbrst_n` stays high.
- R11: The fired flag stays set until software writes status bit 4 as 0. After an expiry the timeout register reads 0.
- R12: While the fired flag is set, nonzero timeout writes do not arm the counter and no further pulse occurs. After the flag is cleared, a new nonzero write arms it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 2 | Register address for write and read |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| kbd_irq | input | 1 | Keyboard interrupt event, sampled each cycle |
| mouse_irq | input | 1 | Mouse interrupt event, sampled each cycle |
| kbd_p20 | input | 1 | Keyboard P20 force input, sampled each cycle |
| fired | output | 1 | Sticky expiry flag |
| kbrst_n | output | 1 | Active-low reset pulse |

## Verification
The bench builds the core with SEC_CYCLES=4, UNITS_PER_MIN=3 and PULSE_CYCLES=3. These values make a one-second unit four cycles long and a minute twelve cycles long, so exact expiry cycles in both scales can be predicted and measured within a few dozen cycles. The short pulse length lets the bench count every low cycle of `kbrst_n` and confirm that no second pulse follows while the flag is held. The timing of reload and rewrite events is placed inside a unit, so that the prescaler restart is visible in the measured expiry cycle.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
package wdt_pkg;
    localparam int REG_W = 8;

    localparam logic [1:0] ADDR_CFG = 2'd0;
    localparam logic [1:0] ADDR_TMO = 2'd1;
    localparam logic [1:0] ADDR_STS = 2'd2;

    localparam int CFG_MIN_BIT   = 3;
    localparam int CFG_P20_BIT   = 2;
    localparam int CFG_PULSE_BIT = 1;

    localparam int STS_MOUSE_BIT = 7;
    localparam int STS_KBD_BIT   = 6;
    localparam int STS_FORCE_BIT = 5;
    localparam int STS_FIRED_BIT = 4;
    localparam int STS_SEL_W     = 4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_PULSE = 2'd2,
        ST_HOLD  = 2'd3
    } wdt_state_e;
endpackage

// File: rtl/wdt_timebase.sv
`timescale 1ns/1ps
module wdt_timebase #(
    parameter int SEC_CYCLES    = 50_000_000,
    parameter int UNITS_PER_MIN = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    input  logic minute_sel,
    output logic unit_tick
);
    localparam int SW = (SEC_CYCLES > 1) ? $clog2(SEC_CYCLES) : 1;

    logic [SW-1:0] sec_q;
    logic          sec_tick;

    assign sec_tick = run && (sec_q == SW'(SEC_CYCLES - 1));

    always_ff @(posedge clk) begin
        if (!rst_n || !run || restart) begin
            sec_q <= '0;
        end else if (sec_tick) begin
            sec_q <= '0;
        end else begin
            sec_q <= sec_q + 1'b1;
        end
    end

    generate
        if (UNITS_PER_MIN > 1) begin : g_minute
            localparam int MW = $clog2(UNITS_PER_MIN);
            logic [MW-1:0] min_q;
            logic          min_tick;

            assign min_tick = sec_tick && (min_q == MW'(UNITS_PER_MIN - 1));

            always_ff @(posedge clk) begin
                if (!rst_n || !run || restart) begin
                    min_q <= '0;
                end else if (min_tick) begin
                    min_q <= '0;
                end else if (sec_tick) begin
                    min_q <= min_q + 1'b1;
                end
            end

            assign unit_tick = minute_sel ? min_tick : sec_tick;
        end else begin : g_flat
            assign unit_tick = minute_sel ? sec_tick : sec_tick;
        end
    endgenerate
endmodule

// File: rtl/wdt_regs.sv
`timescale 1ns/1ps
module wdt_regs
    import wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    input  logic             fire_evt,
    input  logic [REG_W-1:0] count,
    output logic [REG_W-1:0] reg_rdata,
    output logic             minute_sel,
    output logic             p20_en,
    output logic             pulse_en,
    output logic             mouse_en,
    output logic             kbd_en,
    output logic             fired,
    output logic             tmo_wr,
    output logic             force_req
);
    logic                 min_q, p20_q, pulse_q, mouse_q, kbd_q, fired_q;
    logic [STS_SEL_W-1:0] sel_q;
    logic                 cfg_wr, sts_wr;

    assign cfg_wr    = reg_wr && (reg_addr == ADDR_CFG);
    assign sts_wr    = reg_wr && (reg_addr == ADDR_STS);
    assign tmo_wr    = reg_wr && (reg_addr == ADDR_TMO);
    assign force_req = sts_wr && reg_wdata[STS_FORCE_BIT];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            min_q   <= 1'b0;
            p20_q   <= 1'b0;
            pulse_q <= 1'b0;
            mouse_q <= 1'b0;
            kbd_q   <= 1'b0;
            sel_q   <= '0;
            fired_q <= 1'b0;
        end else begin
            if (cfg_wr) begin
                min_q   <= reg_wdata[CFG_MIN_BIT];
                p20_q   <= reg_wdata[CFG_P20_BIT];
                pulse_q <= reg_wdata[CFG_PULSE_BIT];
            end
            if (sts_wr) begin
                mouse_q <= reg_wdata[STS_MOUSE_BIT];
                kbd_q   <= reg_wdata[STS_KBD_BIT];
                sel_q   <= reg_wdata[STS_SEL_W-1:0];
            end
            if (fire_evt) begin
                fired_q <= 1'b1;
            end else if (sts_wr && !reg_wdata[STS_FIRED_BIT]) begin
                fired_q <= 1'b0;
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_CFG: begin
                reg_rdata[CFG_MIN_BIT]   = min_q;
                reg_rdata[CFG_P20_BIT]   = p20_q;
                reg_rdata[CFG_PULSE_BIT] = pulse_q;
            end
            ADDR_TMO: reg_rdata = count;
            ADDR_STS: begin
                reg_rdata[STS_MOUSE_BIT]   = mouse_q;
                reg_rdata[STS_KBD_BIT]     = kbd_q;
                reg_rdata[STS_FIRED_BIT]   = fired_q;
                reg_rdata[STS_SEL_W-1:0]   = sel_q;
            end
            default: reg_rdata = '0;
        endcase
    end

    assign minute_sel = min_q;
    assign p20_en     = p20_q;
    assign pulse_en   = pulse_q;
    assign mouse_en   = mouse_q;
    assign kbd_en     = kbd_q;
    assign fired      = fired_q;
endmodule

// File: rtl/wdt_fsm.sv
`timescale 1ns/1ps
module wdt_fsm
    import wdt_pkg::*;
#(
    parameter int PULSE_CYCLES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tmo_wr,
    input  logic [REG_W-1:0] tmo_data,
    input  logic             fire_req,
    input  logic             irq_reload,
    input  logic             unit_tick,
    input  logic             fired,
    input  logic             pulse_en,
    output wdt_state_e       state,
    output logic [REG_W-1:0] count,
    output logic             fire_evt,
    output logic             tb_run,
    output logic             tb_restart,
    output logic             kbrst_n
);
    localparam int PW = (PULSE_CYCLES > 1) ? $clog2(PULSE_CYCLES) : 1;

    wdt_state_e       state_q, state_d;
    logic [REG_W-1:0] count_q, count_d;
    logic [REG_W-1:0] reload_q, reload_d;
    logic [PW-1:0]    pcnt_q, pcnt_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            count_q  <= '0;
            reload_q <= '0;
            pcnt_q   <= '0;
        end else begin
            state_q  <= state_d;
            count_q  <= count_d;
            reload_q <= reload_d;
            pcnt_q   <= pcnt_d;
        end
    end

    // next state: fire request outranks a timeout write, which outranks an
    // interrupt reload, which outranks the unit tick
    always_comb begin
        state_d    = state_q;
        count_d    = count_q;
        reload_d   = reload_q;
        pcnt_d     = pcnt_q;
        fire_evt   = 1'b0;
        tb_restart = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (fire_req) begin
                    fire_evt = 1'b1;
                end else if (tmo_wr && (tmo_data != '0) && !fired) begin
                    state_d    = ST_COUNT;
                    count_d    = tmo_data;
                    reload_d   = tmo_data;
                    tb_restart = 1'b1;
                end
            end
            ST_COUNT: begin
                if (fire_req) begin
                    fire_evt = 1'b1;
                end else if (tmo_wr) begin
                    if (tmo_data == '0) begin
                        state_d = ST_IDLE;
                        count_d = '0;
                    end else begin
                        count_d    = tmo_data;
                        reload_d   = tmo_data;
                        tb_restart = 1'b1;
                    end
                end else if (irq_reload) begin
                    count_d    = reload_q;
                    tb_restart = 1'b1;
                end else if (unit_tick) begin
                    if (count_q == REG_W'(1)) begin
                        fire_evt = 1'b1;
                    end else begin
                        count_d = count_q - 1'b1;
                    end
                end
            end
            ST_PULSE: begin
                if (pcnt_q == PW'(PULSE_CYCLES - 1)) begin
                    state_d = fired ? ST_HOLD : ST_IDLE;
                end else begin
                    pcnt_d = pcnt_q + 1'b1;
                end
            end
            ST_HOLD: begin
                if (!fired) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
        if (fire_evt) begin
            count_d = '0;
            pcnt_d  = '0;
            state_d = pulse_en ? ST_PULSE : ST_HOLD;
        end
    end

    // outputs
    always_comb begin
        kbrst_n = (state_q != ST_PULSE);
        tb_run  = (state_q == ST_COUNT);
    end

    assign state = state_q;
    assign count = count_q;
endmodule

// File: rtl/wdt_core.sv
`timescale 1ns/1ps
module wdt_core
    import wdt_pkg::*;
#(
    parameter int SEC_CYCLES    = 50_000_000,
    parameter int UNITS_PER_MIN = 60,
    parameter int PULSE_CYCLES  = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       kbd_irq,
    input  logic       mouse_irq,
    input  logic       kbd_p20,
    output logic       fired,
    output logic       kbrst_n
);
    wdt_state_e       state;
    logic [REG_W-1:0] count;
    logic minute_sel, p20_en, pulse_en, mouse_en, kbd_en;
    logic tmo_wr, force_req, fire_evt, fire_req, irq_reload;
    logic tb_run, tb_restart, unit_tick;

    assign fire_req   = force_req || (p20_en && kbd_p20);
    assign irq_reload = (mouse_en && mouse_irq) || (kbd_en && kbd_irq);

    wdt_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .fire_evt   (fire_evt),
        .count      (count),
        .reg_rdata  (reg_rdata),
        .minute_sel (minute_sel),
        .p20_en     (p20_en),
        .pulse_en   (pulse_en),
        .mouse_en   (mouse_en),
        .kbd_en     (kbd_en),
        .fired      (fired),
        .tmo_wr     (tmo_wr),
        .force_req  (force_req)
    );

    wdt_timebase #(
        .SEC_CYCLES    (SEC_CYCLES),
        .UNITS_PER_MIN (UNITS_PER_MIN)
    ) u_tb (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (tb_run),
        .restart    (tb_restart),
        .minute_sel (minute_sel),
        .unit_tick  (unit_tick)
    );

    wdt_fsm #(
        .PULSE_CYCLES (PULSE_CYCLES)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tmo_wr     (tmo_wr),
        .tmo_data   (reg_wdata),
        .fire_req   (fire_req),
        .irq_reload (irq_reload),
        .unit_tick  (unit_tick),
        .fired      (fired),
        .pulse_en   (pulse_en),
        .state      (state),
        .count      (count),
        .fire_evt   (fire_evt),
        .tb_run     (tb_run),
        .tb_restart (tb_restart),
        .kbrst_n    (kbrst_n)
    );
endmodule

// File: rtl/wdt_checker.sv
`timescale 1ns/1ps
module wdt_checker
    import wdt_pkg::*;
#(
    parameter int PULSE_CYCLES = 16
) (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr,
    input logic [1:0] reg_addr,
    input logic [7:0] reg_wdata,
    input logic       fired,
    input logic       kbrst_n,
    input logic [7:0] count,
    input wdt_state_e state
);
    int unsigned low_run;

    always_ff @(posedge clk) begin
        if (!rst_n || kbrst_n) begin
            low_run <= 0;
        end else begin
            low_run <= low_run + 1;
        end
    end

    assert_pulse_needs_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !kbrst_n |-> fired);

    assert_pulse_width_R10: assert property (@(posedge clk) disable iff (!rst_n)
        low_run <= PULSE_CYCLES);

    assert_flag_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (fired && !(reg_wr && reg_addr == ADDR_STS && !reg_wdata[STS_FIRED_BIT])) |=> fired);

    assert_force_fires_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_STS && reg_wdata[STS_FORCE_BIT]
         && (state == ST_IDLE || state == ST_COUNT)) |=> fired);

    assert_zero_disables_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_TMO && reg_wdata == 8'd0) |=> (count == 8'd0));

    assert_hold_no_count_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD) |-> (count == 8'd0));
endmodule

bind wdt_core wdt_checker #(.PULSE_CYCLES(PULSE_CYCLES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .fired     (fired),
    .kbrst_n   (kbrst_n),
    .count     (count),
    .state     (state)
);

// File: tb/sim_wdt_core.sv
`timescale 1ns/1ps
module sim_wdt_core;
    localparam int SEC = 4;
    localparam int MIN = 3;
    localparam int PUL = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       kbd_irq = 1'b0;
    logic       mouse_irq = 1'b0;
    logic       kbd_p20 = 1'b0;
    logic       fired;
    logic       kbrst_n;

    int n_checks = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    wdt_core #(
        .SEC_CYCLES    (SEC),
        .UNITS_PER_MIN (MIN),
        .PULSE_CYCLES  (PUL)
    ) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .kbd_irq   (kbd_irq),
        .mouse_irq (mouse_irq),
        .kbd_p20   (kbd_p20),
        .fired     (fired),
        .kbrst_n   (kbrst_n)
    );

    task automatic chk(input string req, input int actual, input int expected);
        n_checks++;
        if (actual != expected) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        reg_wr = 1'b0;
        kbd_irq = 1'b0;
        mouse_irq = 1'b0;
        kbd_p20 = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_addr = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int d);
        reg_addr = a;
        #1;
        d = int'(reg_rdata);
    endtask

    task automatic wait_fire(input int max, output int c);
        c = 0;
        while (!fired && c < max) begin
            @(negedge clk);
            c++;
        end
    endtask

    task automatic count_low(input int n, output int lows);
        lows = 0;
        repeat (n) begin
            @(negedge clk);
            if (!kbrst_n) lows++;
        end
    endtask

    task automatic t_reset();
        int d;
        do_reset();
        rd(2'd0, d); chk("R1 cfg", d, 0);
        rd(2'd1, d); chk("R1 tmo", d, 0);
        rd(2'd2, d); chk("R1 sts", d, 0);
        chk("R1 fired", int'(fired), 0);
        chk("R1 kbrst_n", int'(kbrst_n), 1);
    endtask

    task automatic t_regmap();
        int d;
        do_reset();
        wr(2'd0, 8'hFF); rd(2'd0, d); chk("R2 cfg bits", d, 8'h0E);
        wr(2'd2, 8'hDF); rd(2'd2, d); chk("R2 sts bits", d, 8'hCF);
        wr(2'd2, 8'h02); rd(2'd2, d); chk("R2 selector SMI", d, 8'h02);
        wr(2'd3, 8'h55); rd(2'd3, d); chk("R2 addr3", d, 0);
        chk("R2 no fire", int'(fired), 0);
    endtask

    task automatic t_seconds();
        int d, c;
        do_reset();
        wr(2'd1, 8'd5);
        repeat (6) @(negedge clk);
        rd(2'd1, d); chk("R3 live count", d, 4);
        wait_fire(200, c);
        chk("R3 expiry cycle", c + 6, 5 * SEC);
    endtask

    task automatic t_minutes();
        int c;
        do_reset();
        wr(2'd0, 8'h08);
        wr(2'd1, 8'd2);
        wait_fire(400, c);
        chk("R4 minute expiry", c, 2 * SEC * MIN);
    endtask

    task automatic t_zero();
        int d;
        do_reset();
        wr(2'd1, 8'd5);
        repeat (6) @(negedge clk);
        wr(2'd1, 8'd0);
        repeat (40) @(negedge clk);
        chk("R5 no fire", int'(fired), 0);
        rd(2'd1, d); chk("R5 count zero", d, 0);
    endtask

    task automatic t_rewrite();
        int c;
        do_reset();
        wr(2'd1, 8'd2);
        repeat (5) @(negedge clk);
        wr(2'd1, 8'd2);
        wait_fire(200, c);
        chk("R6 rearm period", c, 2 * SEC);
    endtask

    task automatic t_irq();
        int c;
        do_reset();
        wr(2'd2, 8'h80);
        wr(2'd1, 8'd3);
        repeat (8) @(negedge clk);
        mouse_irq = 1'b1;
        @(negedge clk);
        mouse_irq = 1'b0;
        wait_fire(200, c);
        chk("R7 mouse reload", c, 3 * SEC);
        do_reset();
        wr(2'd2, 8'h80);
        wr(2'd1, 8'd3);
        repeat (8) @(negedge clk);
        kbd_irq = 1'b1;
        @(negedge clk);
        kbd_irq = 1'b0;
        wait_fire(200, c);
        chk("R7 kbd disabled", c, 3 * SEC - 9);
        do_reset();
        wr(2'd2, 8'h40);
        wr(2'd1, 8'd3);
        repeat (8) @(negedge clk);
        kbd_irq = 1'b1;
        @(negedge clk);
        kbd_irq = 1'b0;
        wait_fire(200, c);
        chk("R7 kbd reload", c, 3 * SEC);
    endtask

    task automatic t_force();
        int d;
        do_reset();
        wr(2'd2, 8'h20);
        chk("R8 immediate fire", int'(fired), 1);
        rd(2'd2, d); chk("R8 force bit reads 0", d, 8'h10);
    endtask

    task automatic t_p20();
        do_reset();
        kbd_p20 = 1'b1;
        repeat (5) @(negedge clk);
        kbd_p20 = 1'b0;
        chk("R9 p20 ignored", int'(fired), 0);
        wr(2'd0, 8'h04);
        kbd_p20 = 1'b1;
        @(negedge clk);
        kbd_p20 = 1'b0;
        chk("R9 p20 fires", int'(fired), 1);
    endtask

    task automatic t_pulse();
        int lows;
        do_reset();
        wr(2'd0, 8'h02);
        wr(2'd1, 8'd1);
        count_low(20, lows);
        chk("R10 pulse length", lows, PUL);
        do_reset();
        wr(2'd1, 8'd1);
        count_low(20, lows);
        chk("R10 no pulse when off", lows, 0);
        chk("R10 fired anyway", int'(fired), 1);
    endtask

    task automatic t_sticky();
        int d, c;
        do_reset();
        wr(2'd1, 8'd1);
        wait_fire(50, c);
        repeat (30) @(negedge clk);
        chk("R11 flag held", int'(fired), 1);
        rd(2'd1, d); chk("R11 tmo reads 0", d, 0);
        wr(2'd2, 8'h00);
        chk("R11 flag cleared", int'(fired), 0);
    endtask

    task automatic t_refire();
        int d, c, lows;
        do_reset();
        wr(2'd0, 8'h02);
        wr(2'd1, 8'd1);
        wait_fire(50, c);
        repeat (5) @(negedge clk);
        wr(2'd1, 8'd5);
        rd(2'd1, d); chk("R12 write not armed", d, 0);
        count_low(40, lows);
        chk("R12 no second pulse", lows, 0);
        chk("R12 flag still set", int'(fired), 1);
        wr(2'd2, 8'h00);
        repeat (2) @(negedge clk);
        wr(2'd1, 8'd1);
        count_low(20, lows);
        chk("R12 rearm after clear", lows, PUL);
    endtask

    initial begin
        t_reset();
        t_regmap();
        t_seconds();
        t_minutes();
        t_zero();
        t_rewrite();
        t_irq();
        t_force();
        t_p20();
        t_pulse();
        t_sticky();
        t_refire();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule